// File: doc/BRIEF.md
# Serial Stereo Level Register with Chained Readback

This block holds the two level codes of a stereo volume stage and loads them over a three-wire serial link. The link has a serial clock, an active-low select and a data line. While select is low, the block shifts in one bit on each rising edge of the serial clock. When select goes high again, the last sixteen bits shifted in are moved into a holding register in one step. The upper byte of that register is the right-channel code and the lower byte is the left-channel code.

While a new word shifts in, the old contents of the holding register leave on a serial output, most significant bit first, and change on falling serial-clock edges. A host can read the current setting this way. Several blocks can also be chained, output to input, so that they form one long shift path under a single select.

Each code is decoded into a mute flag and a signed gain in half-dB units. A mute input forces both channels to mute. All three link pins are brought into the system clock domain through two-flop synchronisers, and their edges are detected in that domain.

Top module: `vol_ctrl_chain`

## Requirements
- R1: While select is low, each rising serial-clock edge shifts in one data bit, most significant first. When a 16-bit frame is committed, the first 8 bits received become right_code_o and the last 8 bits become left_code_o.
- R2: Both channel codes change only when select rises, and they change together at that point. A select pulse with no serial clocks commits the previous contents, so the codes stay the same.
- R3: The serial output carries the holding register contents as they were before the frame, most significant bit first. The first bit is valid after select falls. Each later bit is valid after the next falling serial-clock edge.
- R4: The commit always takes the last 16 bits shifted in. If more than 16 clocks were given, the earlier bits are dropped. If fewer were given, the upper bits come from the previous contents, moved up by the number of clocks.
- R5: In a chain of three blocks sharing clock and select, a 48-bit frame behaves as one 48-bit shift path. The block farthest from the host takes the first 16 bits, the middle block the next 16, and the block nearest the host the last 16. The readback from the far end is the old far, middle and near contents, in that order.
- R6: A channel code of 0 sets that channel's mute flag and reports a gain of 0.
- R7: When mute_i is high, both mute flags are high and the level codes are left unchanged. When mute_i is low, each mute flag follows its own code.
- R8: A nonzero code N reports a signed gain of N-192 half-dB. Code 255 gives +63, code 192 gives 0, code 64 gives -128 and code 1 gives -191.
- R9: After reset, the holding register is zero, both channels are muted with gain 0, and the serial output is 0.
- R10: Serial-clock edges while select is high do not change the codes or the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idle low, asynchronous to clk |
| sel_n_i | input | 1 | Active-low frame select |
| sdin_i | input | 1 | Serial data in |
| mute_i | input | 1 | Forces both channels to mute |
| sdout_o | output | 1 | Serial data out, carrying the previous contents |
| right_code_o | output | 8 | Committed right-channel level code |
| left_code_o | output | 8 | Committed left-channel level code |
| right_mute_o | output | 1 | Right channel muted |
| left_mute_o | output | 1 | Left channel muted |
| right_gain_o | output | 9 | Right gain, signed, in half-dB units |
| left_gain_o | output | 9 | Left gain, signed, in half-dB units |

## Verification
The bench uses the default 8-bit code width, the unity point at code 192 and two synchroniser stages. At these values every corner of the gain decode can be reached: codes 0, 1, 64, 192 and 255. Three instances are chained into one 48-bit path. This makes the slice boundaries, the readback order and frames of 0, 8 and 56 clocks observable at the ports against a 48-bit reference shift register kept in the bench.

// File: rtl/vc_pkg.sv
// Shared constants for the serial stereo level register.
// Assumes: two channels, right in the upper byte of the word.
package vc_pkg;
    localparam int VC_CODE_W      = 8;
    localparam int VC_ZERO_CODE   = 192;
    localparam int VC_SYNC_STAGES = 2;
    localparam int VC_CHANNELS    = 2;
    typedef enum int {VC_CH_RIGHT = 0, VC_CH_LEFT = 1} vc_chan_e;
endpackage

// File: rtl/vc_sync.sv
// Multi-bit level synchroniser: a chain of STAGES flops per bit.
// Assumes: each bit is an independent slow level (no bus coherency needed).
module vc_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        // Purpose: one synchroniser stage, first stage takes the pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[k] <= RST_VAL;
            end else if (k == 0) begin
                stg[k] <= d_i;
            end else begin
                stg[k] <= stg[(k == 0) ? 0 : k-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/vc_shift_core.sv
// Serial shift path, holding register and readback output.
// Detects serial-clock and select edges on already synchronised levels.
// Assumes: each serial-clock half period spans several clk cycles and
// select does not change in the same clk cycle as a serial-clock edge.
module vc_shift_core #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sel_n_s,
    input  logic              din_s,
    output logic [WORD_W-1:0] hold_o,
    output logic              dout_o,
    output logic              commit_o
);
    logic              sclk_d;
    logic              sel_n_d;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] hold_q;
    logic              dout_q;
    logic              sclk_rise, sclk_fall, sel_fall, sel_rise, active;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign sel_fall  = ~sel_n_s & sel_n_d;
    assign sel_rise  = sel_n_s & ~sel_n_d;
    assign active    = ~sel_n_s;

    // Purpose: previous-cycle copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            sel_n_d <= 1'b1;
        end else begin
            sclk_d  <= sclk_s;
            sel_n_d <= sel_n_s;
        end
    end

    // Purpose: preload with current setting at frame start, then shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (sel_fall) begin
            shreg <= hold_q;
        end else if (active && sclk_rise) begin
            shreg <= {shreg[WORD_W-2:0], din_s};
        end
    end

    // Purpose: commit the last WORD_W bits on select release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (sel_rise) begin
            hold_q <= shreg;
        end
    end

    // Purpose: present outgoing bit at frame start and on each falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (sel_fall) begin
            dout_q <= hold_q[WORD_W-1];
        end else if (active && sclk_fall) begin
            dout_q <= shreg[WORD_W-1];
        end
    end

    assign hold_o   = hold_q;
    assign dout_o   = dout_q;
    assign commit_o = sel_rise;
endmodule

// File: rtl/vc_level_decode.sv
// Decodes one channel code into a mute flag and signed half-dB gain.
// Assumes: GAIN_W = CODE_W + 1 so that code - ZERO_CODE always fits.
module vc_level_decode #(
    parameter int CODE_W    = 8,
    parameter int GAIN_W    = 9,
    parameter int ZERO_CODE = 192
) (
    input  logic                     [CODE_W-1:0] code_i,
    input  logic                                  mute_all_i,
    output logic                                  mute_o,
    output logic signed              [GAIN_W-1:0] gain_o
);
    logic                     is_zero;
    logic signed [GAIN_W-1:0] ext;
    logic signed [GAIN_W-1:0] ofs;

    assign is_zero = (code_i == '0);
    assign ext     = $signed(GAIN_W'(code_i));
    assign ofs     = $signed(GAIN_W'(ZERO_CODE));

    // Purpose: mute flag and offset gain for one channel
    always_comb begin
        mute_o = is_zero | mute_all_i;
        gain_o = is_zero ? '0 : (ext - ofs);
    end
endmodule

// File: rtl/vol_ctrl_chain.sv
// Top: serial stereo level register with chained readback.
// Synchronises the link pins, runs the shift core and decodes both bytes.
// Assumes: the serial clock idles low; right channel is the upper byte.
module vol_ctrl_chain
    import vc_pkg::*;
#(
    parameter  int CODE_W      = VC_CODE_W,
    parameter  int ZERO_CODE   = VC_ZERO_CODE,
    parameter  int SYNC_STAGES = VC_SYNC_STAGES,
    localparam int WORD_W      = VC_CHANNELS * CODE_W,
    localparam int GAIN_W      = CODE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_i,
    input  logic                     sel_n_i,
    input  logic                     sdin_i,
    input  logic                     mute_i,
    output logic                     sdout_o,
    output logic        [CODE_W-1:0] right_code_o,
    output logic        [CODE_W-1:0] left_code_o,
    output logic                     right_mute_o,
    output logic                     left_mute_o,
    output logic signed [GAIN_W-1:0] right_gain_o,
    output logic signed [GAIN_W-1:0] left_gain_o
);
    logic [2:0]               pins_s;
    logic                     sclk_s, sel_n_s, din_s;
    logic [WORD_W-1:0]        hold;
    logic                     commit;
    logic [CODE_W-1:0]        codes [VC_CHANNELS];
    logic                     mutes [VC_CHANNELS];
    logic signed [GAIN_W-1:0] gains [VC_CHANNELS];

    vc_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({sel_n_i, sclk_i, sdin_i}),
        .q_o  (pins_s)
    );

    assign sel_n_s = pins_s[2];
    assign sclk_s  = pins_s[1];
    assign din_s   = pins_s[0];

    vc_shift_core #(
        .WORD_W(WORD_W)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sel_n_s (sel_n_s),
        .din_s   (din_s),
        .hold_o  (hold),
        .dout_o  (sdout_o),
        .commit_o(commit)
    );

    for (genvar ch = 0; ch < VC_CHANNELS; ch++) begin : g_chan
        assign codes[ch] = hold[WORD_W-1-ch*CODE_W -: CODE_W];
        vc_level_decode #(
            .CODE_W   (CODE_W),
            .GAIN_W   (GAIN_W),
            .ZERO_CODE(ZERO_CODE)
        ) dec_i (
            .code_i    (codes[ch]),
            .mute_all_i(mute_i),
            .mute_o    (mutes[ch]),
            .gain_o    (gains[ch])
        );
    end

    assign right_code_o = codes[VC_CH_RIGHT];
    assign left_code_o  = codes[VC_CH_LEFT];
    assign right_mute_o = mutes[VC_CH_RIGHT];
    assign left_mute_o  = mutes[VC_CH_LEFT];
    assign right_gain_o = gains[VC_CH_RIGHT];
    assign left_gain_o  = gains[VC_CH_LEFT];
endmodule

// File: rtl/vc_chk.sv
// Property checker for vol_ctrl_chain, attached by bind below.
module vc_chk #(
    parameter int CODE_W    = 8,
    parameter int GAIN_W    = 9,
    parameter int ZERO_CODE = 192
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mute_i,
    input logic                     sel_n_s,
    input logic                     commit,
    input logic                     sdout_o,
    input logic        [CODE_W-1:0] right_code_o,
    input logic        [CODE_W-1:0] left_code_o,
    input logic                     right_mute_o,
    input logic                     left_mute_o,
    input logic signed [GAIN_W-1:0] right_gain_o,
    input logic signed [GAIN_W-1:0] left_gain_o
);
    // R2
    codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({right_code_o, left_code_o}));

    // R7
    mute_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_i |-> (right_mute_o && left_mute_o));

    // R6
    zero_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (right_code_o == '0) |-> (right_mute_o && right_gain_o == '0));

    // R6
    zero_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_code_o == '0) |-> (left_mute_o && left_gain_o == '0));

    // R8
    unity_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (right_code_o >= CODE_W'(ZERO_CODE)) |-> !right_gain_o[GAIN_W-1]);

    // R10
    dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> $stable(sdout_o));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (right_code_o == '0 && left_code_o == '0 && !sdout_o));
endmodule

bind vol_ctrl_chain vc_chk #(
    .CODE_W   (CODE_W),
    .GAIN_W   (GAIN_W),
    .ZERO_CODE(ZERO_CODE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mute_i      (mute_i),
    .sel_n_s     (sel_n_s),
    .commit      (commit),
    .sdout_o     (sdout_o),
    .right_code_o(right_code_o),
    .left_code_o (left_code_o),
    .right_mute_o(right_mute_o),
    .left_mute_o (left_mute_o),
    .right_gain_o(right_gain_o),
    .left_gain_o (left_gain_o)
);

// File: tb/vol_ctrl_chain_tb_top.sv
// Bench: three chained instances against a 48-bit reference shift path.
module vol_ctrl_chain_tb_top;
    localparam int CLK_P = 10;
    localparam int HALF  = 8 * CLK_P;
    localparam int NVEC  = 6;
    localparam logic [47:0] VEC [NVEC] = '{
        48'hC0C0_FF01_0040,
        48'h1234_5678_FF01,
        48'h0000_ABCD_C0FF,
        48'hFFFF_0000_00C0,
        48'h8001_7E7E_0000,
        48'hA5A5_5A5A_8180
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sel_n = 1'b1;
    logic sdin = 1'b0;
    logic mute = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    logic [47:0] chain_m = '0;

    logic              d0_out, d1_out, d2_out;
    logic [7:0]        d0_r, d0_l, d1_r, d1_l, d2_r, d2_l;
    logic              d0_rm, d0_lm, d1_rm, d1_lm, d2_rm, d2_lm;
    logic signed [8:0] d0_rg, d0_lg, d1_rg, d1_lg, d2_rg, d2_lg;

    always #(CLK_P/2) clk = ~clk;

    vol_ctrl_chain dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n),
        .sdin_i(sdin), .mute_i(mute), .sdout_o(d0_out),
        .right_code_o(d0_r), .left_code_o(d0_l),
        .right_mute_o(d0_rm), .left_mute_o(d0_lm),
        .right_gain_o(d0_rg), .left_gain_o(d0_lg));

    vol_ctrl_chain mid_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n),
        .sdin_i(d0_out), .mute_i(mute), .sdout_o(d1_out),
        .right_code_o(d1_r), .left_code_o(d1_l),
        .right_mute_o(d1_rm), .left_mute_o(d1_lm),
        .right_gain_o(d1_rg), .left_gain_o(d1_lg));

    vol_ctrl_chain far_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n),
        .sdin_i(d1_out), .mute_i(mute), .sdout_o(d2_out),
        .right_code_o(d2_r), .left_code_o(d2_l),
        .right_mute_o(d2_rm), .left_mute_o(d2_lm),
        .right_gain_o(d2_rg), .left_gain_o(d2_lg));

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_gain(input logic [7:0] code);
        return (code == 8'd0) ? 0 : int'(code) - 192;
    endfunction

    task automatic check_state(input string tag);
        chk({d0_r, d0_l} == chain_m[15:0], {"R1 near word ", tag},
            {d0_r, d0_l}, chain_m[15:0]);
        chk({d1_r, d1_l} == chain_m[31:16], {"R5 middle word ", tag},
            {d1_r, d1_l}, chain_m[31:16]);
        chk({d2_r, d2_l} == chain_m[47:32], {"R5 far word ", tag},
            {d2_r, d2_l}, chain_m[47:32]);
        chk(int'(d0_rg) == exp_gain(chain_m[15:8]), {"R8 right gain ", tag},
            64'(d0_rg), 64'(exp_gain(chain_m[15:8])));
        chk(int'(d0_lg) == exp_gain(chain_m[7:0]), {"R8 left gain ", tag},
            64'(d0_lg), 64'(exp_gain(chain_m[7:0])));
        chk({d0_rm, d0_lm} == {chain_m[15:8] == 8'd0, chain_m[7:0] == 8'd0},
            {"R6 mute flags ", tag}, {d0_rm, d0_lm},
            {chain_m[15:8] == 8'd0, chain_m[7:0] == 8'd0});
    endtask

    // Shift n bits (MSB first) through the chain under one select frame
    task automatic frame(input int n, input logic [63:0] bits, input string tag);
        logic [63:0] rb;
        logic [63:0] erb;
        rb  = '0;
        erb = '0;
        sel_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            sdin    = bits[n-1-i];
            erb     = {erb[62:0], chain_m[47]};
            chain_m = {chain_m[46:0], bits[n-1-i]};
            #(HALF);
            rb   = {rb[62:0], d2_out};
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
        #(HALF);
        sel_n = 1'b1;
        #(HALF);
        chk(rb == erb, {"R3 readback ", tag}, rb, erb);
        check_state(tag);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] save_codes;
        logic        save_out;
        #(CLK_P * 5);
        rst_n = 1'b1;
        #(CLK_P * 4);
        // R9 reset state
        chk({d0_r, d0_l, d2_r, d2_l} == 32'd0, "R9 codes zero", {d0_r, d0_l}, 0);
        chk({d0_rm, d0_lm} == 2'b11, "R9 muted", {d0_rm, d0_lm}, 2'b11);
        chk(d0_rg == 9'sd0 && d0_lg == 9'sd0, "R9 gain zero", d0_rg, 0);
        chk(d2_out == 1'b0, "R9 serial out", d2_out, 0);

        // R1 R3 R5 R6 R8 table walk
        for (int v = 0; v < NVEC; v++) begin
            frame(48, 64'(VEC[v]), $sformatf("vec%0d", v));
        end

        // R7 mute input forces both flags, codes kept
        mute = 1'b1;
        #(CLK_P * 2);
        chk({d0_rm, d0_lm, d1_rm, d1_lm} == 4'hF, "R7 forced mute",
            {d0_rm, d0_lm, d1_rm, d1_lm}, 4'hF);
        chk({d1_r, d1_l} == chain_m[31:16], "R7 codes kept", {d1_r, d1_l}, chain_m[31:16]);
        mute = 1'b0;
        #(CLK_P * 2);
        chk({d1_rm, d1_lm} == 2'b00, "R7 mute released", {d1_rm, d1_lm}, 2'b00);

        // R2 select pulse without clocks keeps codes
        frame(0, 64'd0, "R2 empty frame");

        // R4 short and long frames
        frame(8, 64'h3C, "R4 short");
        frame(56, 64'h00_11C0_2201_33FF, "R4 long");

        // R10 serial clock while select high
        save_codes = {d0_r, d0_l};
        save_out   = d2_out;
        for (int p = 0; p < 4; p++) begin
            sdin = ~sdin;
            #(HALF); sclk = 1'b1; #(HALF); sclk = 0;
        end
        #(HALF);
        chk({d0_r, d0_l} == save_codes, "R10 codes unchanged", {d0_r, d0_l}, save_codes);
        chk(d2_out == save_out, "R10 output unchanged", d2_out, save_out);
        frame(48, 48'h0001_C0C0_FF00, "R10 after idle clocks");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule